// File: doc/BRIEF.md
# Phase-Accumulator Sine Oscillator

The block produces a stream of signed sine samples whose frequency is set by a number. It keeps a wrapping phase word that counts fractions of one turn around the unit circle. A full turn equals 2^W counts. A load strobe captures a step value, which is the per-sample phase increment already expressed in phase counts. Each clock with the advance enable high adds the held step to the phase. Carries out of the top bit are dropped, so the phase wraps the way an angle does.

The upper P bits of the phase select one entry of a full-cycle sine table of 2^P signed entries. Each entry is the sine value at the start of its phase interval. The table is computed during elaboration. The lower phase bits only carry the fractional part of the step. At step rates that are not a whole number of entries, the table index therefore skips or repeats entries from time to time.

The selected entry is registered as the output sample, together with a valid flag that follows the advance enable. After reset the step is zero, so the oscillator holds a constant output until a frequency is loaded.

Top module: `phase_nco`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the phase, the step and the output sample to zero and drops valid_o. With no step loaded, advancing leaves phase_o at 0 and sample_o at 0.
- R2: A clock edge with load_i high captures step_i as the new step, unchanged, with no unit conversion. Without load_i the held step does not change.
- R3: A clock edge with ce_i high sets phase_o to (phase_o + step) modulo 2^32. Any carry out of bit 31 is discarded.
- R4: A clock edge with ce_i low leaves phase_o unchanged.
- R5: When load_i and ce_i are both high on the same edge, the phase advances by the old step. The newly loaded step applies from the next advancing edge.
- R6: The table index is phase_o[31:24], the top 8 bits of the phase. Bits 23:0 only accumulate fractional steps.
- R7: Table entry k, for k from 0 to 255, is the 12-bit two's complement value round(2047*sin(2*pi*k/256)).
- R8: One edge after an advancing edge, valid_o is high and sample_o holds the table entry selected by the phase that advance produced. After an edge where ce_i was low, valid_o is low one edge later and sample_o keeps its value.
- R9: Loading step 0x2000_0000 and advancing once reaches phase 0x2000_0000. After step 0x4000_0000 is loaded, further advances give 0x6000_0000, 0xA000_0000, 0xE000_0000 and then 0x2000_0000 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture step_i as the new phase step |
| step_i | input | 32 | Phase step in counts per sample (2^32 = one turn) |
| ce_i | input | 1 | Advance the phase by the held step on this clock |
| phase_o | output | 32 | Current phase word |
| sample_o | output | 12 | Registered signed sine sample |
| valid_o | output | 1 | Marks the cycle in which sample_o was refreshed by an advance |

## Verification
The assertions assume that load_i, step_i and ce_i are known and stable around every rising clock edge once reset has been released. They make no assumption about how often load_i or ce_i are asserted, or whether they coincide. The stimulus changes inputs only on falling edges. It mixes random steps, some small enough to make the index repeat and some large enough to make it skip, with random load and enable patterns, including loads that land on the same edge as an advance. Directed cases cover the zero-step state after reset, the quarter-turn sequence that wraps past the top of the phase, and long idle stretches with ce_i low.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int unsigned DEF_PHASE_W  = 32;
    localparam int unsigned DEF_IDX_W    = 8;
    localparam int unsigned DEF_SAMPLE_W = 12;

    localparam real PI_R     = 3.14159265358979323846;
    localparam real TWO_PI_R = 2.0 * PI_R;

    // Fold an angle into [-pi, pi] so the series converges quickly.
    function automatic real fold_angle(input real x);
        real a;
        a = x;
        while (a > PI_R) a = a - TWO_PI_R;
        while (a < -PI_R) a = a + TWO_PI_R;
        return a;
    endfunction

    // Odd power series for sine; enough terms for better than 1e-6 on [-pi, pi].
    function automatic real series_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 12; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Round half away from zero.
    function automatic int round_real(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int unsigned PHASE_W = nco_pkg::DEF_PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [PHASE_W-1:0] step_i,
    input  logic               adv_i,
    output logic [PHASE_W-1:0] phase_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [PHASE_W-1:0] inc;
    } acc_t;

    acc_t acc_d;
    acc_t acc_q;

    always_comb begin
        acc_d = acc_q;
        if (adv_i) begin
            // carry out of the top bit is dropped: modulo 2^PHASE_W
            acc_d.phase = acc_q.phase + acc_q.inc;
        end
        if (load_i) begin
            acc_d.inc = step_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign phase_o = acc_q.phase;

    // R4: no advance, no phase movement
    p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(acc_q.phase));

    // R2: load captures the step as given
    p_step_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> acc_q.inc == $past(step_i));

    // R2: step is held without a load
    p_step_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(acc_q.inc));

    // R5: a coincident load does not change the increment used on that edge
    p_old_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && load_i) |=> acc_q.phase == $past(acc_q.phase) + $past(acc_q.inc));

    // R3: a step of zero never moves the phase
    p_zero_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.inc == '0) |=> $stable(acc_q.phase));

endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
    parameter int unsigned IDX_W    = nco_pkg::DEF_IDX_W,
    parameter int unsigned SAMPLE_W = nco_pkg::DEF_SAMPLE_W
) (
    input  logic [IDX_W-1:0]           idx_i,
    output logic signed [SAMPLE_W-1:0] value_o
);

    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int          AMP   = (1 << (SAMPLE_W - 1)) - 1;

    logic signed [SAMPLE_W-1:0] table_w [DEPTH];

    // Left-edge sampling: entry g holds sin(2*pi*g/DEPTH).
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int ENTRY = nco_pkg::round_real(real'(AMP) *
            nco_pkg::series_sin(nco_pkg::fold_angle(
                nco_pkg::TWO_PI_R * real'(g) / real'(DEPTH))));
        assign table_w[g] = SAMPLE_W'(ENTRY);
    end

    assign value_o = table_w[idx_i];

endmodule

// File: rtl/nco_sample_reg.sv
module nco_sample_reg #(
    parameter int unsigned SAMPLE_W = nco_pkg::DEF_SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv_i,
    input  logic signed [SAMPLE_W-1:0] value_i,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       valid_o
);

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        logic                valid;
    } out_t;

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d       = out_q;
        out_d.valid = adv_i;
        if (adv_i) begin
            out_d.sample = value_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_o = signed'(out_q.sample);
    assign valid_o  = out_q.valid;

    // R8: a cycle without refresh keeps the previous sample
    p_sample_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(out_q.sample));

endmodule

// File: rtl/phase_nco.sv
module phase_nco #(
    parameter int unsigned PHASE_W  = nco_pkg::DEF_PHASE_W,
    parameter int unsigned IDX_W    = nco_pkg::DEF_IDX_W,
    parameter int unsigned SAMPLE_W = nco_pkg::DEF_SAMPLE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [PHASE_W-1:0]         step_i,
    input  logic                       ce_i,
    output logic [PHASE_W-1:0]         phase_o,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       valid_o
);

    localparam int unsigned IDX_LSB = PHASE_W - IDX_W;

    logic                       adv_d;
    logic                       adv_q;
    logic [PHASE_W-1:0]         phase_w;
    logic [IDX_W-1:0]           idx_w;
    logic signed [SAMPLE_W-1:0] rom_w;

    nco_phase_acc #(
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .step_i  (step_i),
        .adv_i   (ce_i),
        .phase_o (phase_w)
    );

    // R6: only the top IDX_W bits address the table
    assign idx_w = phase_w[PHASE_W-1:IDX_LSB];

    nco_sine_rom #(
        .IDX_W    (IDX_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_rom (
        .idx_i   (idx_w),
        .value_o (rom_w)
    );

    // Remember that the phase just moved, so the table lookup of the new
    // phase is registered on the following edge.
    always_comb begin
        adv_d = ce_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
        end else begin
            adv_q <= adv_d;
        end
    end

    nco_sample_reg #(
        .SAMPLE_W (SAMPLE_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv_q),
        .value_i  (rom_w),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    assign phase_o = phase_w;

    // R8: an advance is followed two edges later by a valid sample
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ce_i |=> ##1 valid_o);

    // R8: no advance, no valid two edges later
    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> ##1 !valid_o);

    // R7: amplitude never reaches the most negative code
    p_amp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

// File: tb/phase_nco_test.sv
`timescale 1ns/1ps
module phase_nco_test;

    localparam real PI_V = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               load_i;
    logic [31:0]        step_i;
    logic               ce_i;
    logic [31:0]        phase_o;
    logic signed [11:0] sample_o;
    logic               valid_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_phase;
    logic [31:0] m_inc;
    logic        m_adv;
    logic        m_valid;
    int          m_sample;

    always #2.5 clk = ~clk;

    phase_nco uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .step_i   (step_i),
        .ce_i     (ce_i),
        .phase_o  (phase_o),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    function automatic int ref_entry(input int k);
        real v;
        v = 2047.0 * $sin(2.0 * PI_V * real'(k) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h) t=%0t",
                     req, act, act, exp, exp, $time);
        end
    endtask

    task automatic compare_all();
        int d;
        chk(phase_o == m_phase, "R3 phase", phase_o, m_phase);
        chk(phase_o[31:24] == m_phase[31:24], "R6 index", phase_o[31:24], m_phase[31:24]);
        chk(valid_o == m_valid, "R8 valid", valid_o, m_valid);
        d = int'(sample_o) - m_sample;
        chk(d >= -1 && d <= 1, "R7 sample", sample_o, m_sample);
    endtask

    // Called at a falling edge; applies inputs, waits one rising edge,
    // updates the model and compares at the next falling edge.
    task automatic cyc(input bit ld, input logic [31:0] st, input bit en);
        load_i = ld;
        step_i = st;
        ce_i   = en;
        @(posedge clk);
        if (m_adv) m_sample = ref_entry(int'(m_phase[31:24]));
        m_valid = m_adv;
        m_adv   = en;
        if (en) m_phase = m_phase + m_inc;
        if (ld) m_inc = st;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; load_i = 1'b0; step_i = '0; ce_i = 1'b0;
        m_phase = '0; m_inc = '0; m_adv = 1'b0; m_valid = 1'b0; m_sample = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(phase_o == 0, "R1 reset phase", phase_o, 0);
        chk(sample_o == 0, "R1 reset sample", sample_o, 0);
        chk(valid_o == 0, "R1 reset valid", valid_o, 0);
        // R1: zero step keeps phase and output at zero
        for (int i = 0; i < 4; i++) cyc(1'b0, 32'hFFFF_FFFF, 1'b1);
        chk(phase_o == 0, "R1 zero step phase", phase_o, 0);
        chk(sample_o == 0, "R1 zero step sample", sample_o, 0);

        // R9 and R5: quarter-turn sequence
        cyc(1'b1, 32'h2000_0000, 1'b0);
        cyc(1'b1, 32'h4000_0000, 1'b1);
        chk(phase_o == 32'h2000_0000, "R5 old step used", phase_o, 32'h2000_0000);
        cyc(1'b0, 32'h0, 1'b1);
        chk(phase_o == 32'h6000_0000, "R9 step 1", phase_o, 32'h6000_0000);
        cyc(1'b0, 32'h0, 1'b1);
        chk(phase_o == 32'hA000_0000, "R9 step 2", phase_o, 32'hA000_0000);
        cyc(1'b0, 32'h0, 1'b1);
        chk(phase_o == 32'hE000_0000, "R9 step 3", phase_o, 32'hE000_0000);
        cyc(1'b0, 32'h0, 1'b1);
        chk(phase_o == 32'h2000_0000, "R9 wrap", phase_o, 32'h2000_0000);

        // R4 and R8: idle stretch holds phase and sample
        held = phase_o;
        for (int i = 0; i < 5; i++) cyc(1'b0, 32'h1234_5678, 1'b0);
        chk(phase_o == held, "R4 hold phase", phase_o, held);
        chk(valid_o == 0, "R8 valid low when idle", valid_o, 0);

        // R2: step captured unchanged; check by one advance
        cyc(1'b1, 32'h0000_0001, 1'b0);
        cyc(1'b0, 32'h0, 1'b1);
        chk(phase_o == held + 32'd1, "R2 exact step", phase_o, held + 32'd1);

        // R3: carry discarded near the top
        cyc(1'b1, 32'hFFFF_FFF0, 1'b1);
        cyc(1'b0, 32'h0, 1'b1);
        chk(phase_o == held + 32'd2 + 32'hFFFF_FFF0, "R3 wrap", phase_o, held + 32'd2 + 32'hFFFF_FFF0);

        // R6: fractional step, index repeats (0.75 entry per sample)
        cyc(1'b1, 32'h00C0_0000, 1'b0);
        for (int i = 0; i < 300; i++) cyc(1'b0, 32'h0, 1'b1);
        // index skips (2.5 entries per sample)
        cyc(1'b1, 32'h0280_0000, 1'b1);
        for (int i = 0; i < 300; i++) cyc(1'b0, 32'h0, 1'b1);

        // Random mix of loads, enables and step sizes
        for (int i = 0; i < 4000; i++) begin
            bit          ld;
            bit          en;
            logic [31:0] st;
            ld = ($urandom % 8) == 0;
            en = ($urandom % 4) != 0;
            case ($urandom % 3)
                0:       st = $urandom % 32'h0100_0000;
                1:       st = $urandom;
                default: st = 32'h0100_0000 * ($urandom % 16);
            endcase
            cyc(ld, st, en);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule